// File: doc/BRIEF.md
# DDR2 Command Timing Gate

This block sits between a DDR2 command scheduler and the command encoder of an eight-bank device. Each command comes in with a 3-bit operation code and a bank number on a valid/ready handshake. The gate raises `cmd_ready` only in a cycle where issuing that command would respect every minimum spacing the device requires. The scheduler holds the command until it is accepted. A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both high.

The gate keeps three kinds of timing state. Each bank has its own countdown timers. A short history of recent activates enforces the four-activate window. Global timers cover refresh recovery, mode-register recovery, precharge-all recovery and write-to-read turnaround. All minimums are elaboration parameters in clock cycles. The defaults suit a 2.5 ns clock with read latency 5 and burst length 4. Write-derived windows are counted from the end of the write burst, which falls write latency plus half the burst length after the WRITE.

Commands that are illegal for the current bank state raise `cmd_err` instead of `cmd_ready`. The timing state does not change for such a command, so the scheduler can drop it or correct it.

Top module: `ddr2_timing_gate`

## Requirements
- R1: Command codes are 0 activate, 1 read, 2 write, 3 precharge one bank, 4 precharge all, 5 refresh, 6 mode-register set, and 7 is reserved. After reset all banks are closed, and `cmd_ready` and `cmd_err` are low whenever `cmd_valid` is low. An activate presented right after reset is accepted in its first cycle.
- R2: A read or write to a bank is accepted no earlier than 5 cycles after that bank's activate.
- R3: A precharge of a bank waits 18 cycles after its activate. A re-activate waits 5 cycles after the precharge and 23 cycles after the previous activate of the same bank.
- R4: Activates to different banks are at least 3 cycles apart.
- R5: At most four activates are accepted within any 14 cycles. A fifth is held until 14 cycles after the oldest of the last four.
- R6: After precharge-all, activate, refresh and mode-register set are held for 6 cycles.
- R7: After a refresh, the next activate or refresh waits 78 cycles.
- R8: After a mode-register set, no command is accepted for 2 cycles.
- R9: A precharge waits 12 cycles after a write to the same bank and 3 cycles after a read to the same bank.
- R10: A read to any bank waits 9 cycles after a write.
- R11: Each of the following raises `cmd_err`, keeps `cmd_ready` low and leaves all timing state unchanged: a read or write to a closed bank, an activate to an open bank, a refresh or mode-register set while any bank is open, and code 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (see R1) |
| cmd_bank | input | 3 | Target bank |
| cmd_ready | output | 1 | Command may issue this cycle |
| cmd_err | output | 1 | Command is illegal for the current bank state |

## Verification
A wrong countdown value or a lost open-bank bit shows at the ports in the cycle the next dependent command is presented. `cmd_ready` rises one or more cycles too early or too late compared with the spacing the requirements give, or `cmd_err` takes the wrong value. Every scenario places the dependent command right after its predecessor, so a timer that is off by one shows in the accept cycle. The error cases then present a legal command whose accept cycle shows whether the rejected command disturbed any state.

// File: rtl/ddr2_tc_pkg.sv
package ddr2_tc_pkg;
    localparam int CNT_W = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        OP_ACT  = 3'd0,
        OP_RD   = 3'd1,
        OP_WR   = 3'd2,
        OP_PRE  = 3'd3,
        OP_PREA = 3'd4,
        OP_REF  = 3'd5,
        OP_MRS  = 3'd6,
        OP_RSV  = 3'd7
    } op_e;

    // countdown step: decrement toward zero, then take the larger of that and a new load
    function automatic cnt_t tick(input cnt_t cur, input cnt_t load);
        cnt_t dec;
        dec = (cur == '0) ? '0 : cur - 1'b1;
        return (load > dec) ? load : dec;
    endfunction
endpackage

// File: rtl/ddr2_tc_bank.sv
module ddr2_tc_bank
    import ddr2_tc_pkg::*;
#(
    parameter int T_RCD   = 5,
    parameter int T_RAS   = 18,
    parameter int T_RC    = 23,
    parameter int T_RP    = 5,
    parameter int T_RTP   = 3,
    parameter int T_WRPRE = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic pre_i,
    input  logic prea_i,
    output logic open_o,
    output logic rdwr_ok_o,
    output logic pre_ok_o,
    output logic act_ok_o
);
    typedef struct packed {
        logic open;
        cnt_t rcd;
        cnt_t pre;
        cnt_t act;
    } bank_st_t;

    bank_st_t s_q, s_d;
    cnt_t     pre_load, act_load;

    always_comb begin
        s_d = s_q;
        if (act_i)
            s_d.open = 1'b1;
        else if (pre_i || prea_i)
            s_d.open = 1'b0;

        if (act_i)      pre_load = cnt_t'(T_RAS - 1);
        else if (rd_i)  pre_load = cnt_t'(T_RTP - 1);
        else if (wr_i)  pre_load = cnt_t'(T_WRPRE - 1);
        else            pre_load = '0;

        if (act_i)                 act_load = cnt_t'(T_RC - 1);
        else if (pre_i || prea_i)  act_load = cnt_t'(T_RP - 1);
        else                       act_load = '0;

        s_d.rcd = tick(s_q.rcd, act_i ? cnt_t'(T_RCD - 1) : '0);
        s_d.pre = tick(s_q.pre, pre_load);
        s_d.act = tick(s_q.act, act_load);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign open_o    = s_q.open;
    assign rdwr_ok_o = (s_q.rcd == '0);
    assign pre_ok_o  = (s_q.pre == '0);
    assign act_ok_o  = (s_q.act == '0);
endmodule

// File: rtl/ddr2_tc_faw.sv
module ddr2_tc_faw
    import ddr2_tc_pkg::*;
#(
    parameter int T_FAW = 14,
    parameter int N_ACT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    output logic ok_o
);
    cnt_t slot_q [N_ACT];
    cnt_t slot_d [N_ACT];

    always_comb begin
        for (int i = 0; i < N_ACT; i++) begin
            if (!act_i)
                slot_d[i] = tick(slot_q[i], '0);
            else if (i == 0)
                slot_d[i] = cnt_t'(T_FAW - 1);
            else
                slot_d[i] = tick(slot_q[i-1], '0);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_ACT; i++) begin
            if (!rst_n) slot_q[i] <= '0;
            else        slot_q[i] <= slot_d[i];
        end
    end

    assign ok_o = (slot_q[N_ACT-1] == '0);
endmodule

// File: rtl/ddr2_timing_gate.sv
module ddr2_timing_gate
    import ddr2_tc_pkg::*;
#(
    parameter int N_BANK = 8,
    parameter int T_RCD  = 5,
    parameter int T_RP   = 5,
    parameter int T_RAS  = 18,
    parameter int T_RC   = 23,
    parameter int T_RRD  = 3,
    parameter int T_FAW  = 14,
    parameter int N_FAW  = 4,
    parameter int T_RFC  = 78,
    parameter int T_MRD  = 2,
    parameter int T_WR   = 6,
    parameter int T_RTP  = 3,
    parameter int T_WTR  = 3,
    parameter int CL     = 5,
    parameter int BL     = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [2:0]                cmd_op,
    input  logic [$clog2(N_BANK)-1:0] cmd_bank,
    output logic                      cmd_ready,
    output logic                      cmd_err
);
    localparam int BA_W    = $clog2(N_BANK);
    localparam int WL      = CL - 1;
    localparam int WR_END  = WL + BL / 2;
    localparam int T_WRPRE = WR_END + T_WR;
    localparam int T_WRRD  = WR_END + T_WTR;
    localparam int T_RPA   = T_RP + 1;

    typedef struct packed {
        cnt_t rrd;
        cnt_t wtr;
        cnt_t all;
    } glob_st_t;

    glob_st_t g_q, g_d;
    op_e      op;
    logic     acc, err_c, time_ok, faw_ok;
    logic [N_BANK-1:0] open_w, rdwr_ok, pre_ok, act_ok, sel;
    logic [N_BANK-1:0] act_s, rd_s, wr_s, pre_s;
    cnt_t     all_load;

    assign op  = op_e'(cmd_op);
    assign acc = cmd_valid && cmd_ready;

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        assign sel[b]   = (cmd_bank == BA_W'(b));
        assign act_s[b] = acc && sel[b] && (op == OP_ACT);
        assign rd_s[b]  = acc && sel[b] && (op == OP_RD);
        assign wr_s[b]  = acc && sel[b] && (op == OP_WR);
        assign pre_s[b] = acc && sel[b] && (op == OP_PRE);

        ddr2_tc_bank #(
            .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP),
            .T_RTP(T_RTP), .T_WRPRE(T_WRPRE)
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .act_i(act_s[b]), .rd_i(rd_s[b]), .wr_i(wr_s[b]), .pre_i(pre_s[b]),
            .prea_i(acc && (op == OP_PREA)),
            .open_o(open_w[b]), .rdwr_ok_o(rdwr_ok[b]),
            .pre_ok_o(pre_ok[b]), .act_ok_o(act_ok[b])
        );
    end

    ddr2_tc_faw #(.T_FAW(T_FAW), .N_ACT(N_FAW)) u_faw (
        .clk(clk), .rst_n(rst_n),
        .act_i(acc && (op == OP_ACT)),
        .ok_o(faw_ok)
    );

    always_comb begin
        unique case (op)
            OP_ACT:         err_c = open_w[cmd_bank];
            OP_RD, OP_WR:   err_c = !open_w[cmd_bank];
            OP_REF, OP_MRS: err_c = |open_w;
            OP_RSV:         err_c = 1'b1;
            default:        err_c = 1'b0;
        endcase

        unique case (op)
            OP_ACT:         time_ok = act_ok[cmd_bank] && (g_q.rrd == '0) && faw_ok;
            OP_RD:          time_ok = rdwr_ok[cmd_bank] && (g_q.wtr == '0);
            OP_WR:          time_ok = rdwr_ok[cmd_bank];
            OP_PRE:         time_ok = pre_ok[cmd_bank];
            OP_PREA:        time_ok = &pre_ok;
            OP_REF, OP_MRS: time_ok = &act_ok;
            default:        time_ok = 1'b0;
        endcase
        time_ok = time_ok && (g_q.all == '0);

        if (acc && op == OP_REF)       all_load = cnt_t'(T_RFC - 1);
        else if (acc && op == OP_MRS)  all_load = cnt_t'(T_MRD - 1);
        else if (acc && op == OP_PREA) all_load = cnt_t'(T_RPA - 1);
        else                           all_load = '0;

        g_d.rrd = tick(g_q.rrd, (acc && op == OP_ACT) ? cnt_t'(T_RRD - 1) : '0);
        g_d.wtr = tick(g_q.wtr, (acc && op == OP_WR) ? cnt_t'(T_WRRD - 1) : '0);
        g_d.all = tick(g_q.all, all_load);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign cmd_err   = cmd_valid && err_c;
    assign cmd_ready = cmd_valid && !err_c && time_ok;
endmodule

// File: rtl/ddr2_tc_chk.sv
module ddr2_tc_chk #(
    parameter int N_BANK = 8,
    parameter int T_RCD  = 5,
    parameter int T_RRD  = 3,
    parameter int T_RFC  = 78
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cmd_valid,
    input logic [2:0]                cmd_op,
    input logic [$clog2(N_BANK)-1:0] cmd_bank,
    input logic                      cmd_ready,
    input logic                      cmd_err
);
    logic       acc;
    logic [7:0] since_act [N_BANK];
    logic [7:0] since_any, since_ref;

    assign acc = cmd_valid && cmd_ready;

    function automatic logic [7:0] up(input logic [7:0] v);
        return (v == 8'hFF) ? v : v + 8'd1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < N_BANK; b++) since_act[b] <= 8'hFF;
            since_any <= 8'hFF;
            since_ref <= 8'hFF;
        end else begin
            for (int b = 0; b < N_BANK; b++)
                since_act[b] <= (acc && cmd_op == 3'd0 && int'(cmd_bank) == b) ? 8'd1 : up(since_act[b]);
            since_any <= (acc && cmd_op == 3'd0) ? 8'd1 : up(since_any);
            since_ref <= (acc && cmd_op == 3'd5) ? 8'd1 : up(since_ref);
        end
    end

    p_rcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (cmd_op == 3'd1 || cmd_op == 3'd2) |-> since_act[cmd_bank] >= 8'(T_RCD));

    p_rrd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cmd_op == 3'd0 |-> since_any >= 8'(T_RRD));

    p_rfc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (cmd_op == 3'd0 || cmd_op == 3'd5) |-> since_ref >= 8'(T_RFC));

    p_mrs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cmd_op == 3'd6 |=> !cmd_ready);

    p_err_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !cmd_ready);
endmodule

bind ddr2_timing_gate ddr2_tc_chk #(
    .N_BANK(N_BANK), .T_RCD(T_RCD), .T_RRD(T_RRD), .T_RFC(T_RFC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_ready(cmd_ready), .cmd_err(cmd_err)
);

// File: tb/ddr2_timing_gate_test.sv
module ddr2_timing_gate_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [2:0] cmd_bank = '0;
    logic       cmd_ready, cmd_err;
    int cyc = 0;
    int checks = 0;
    int fails = 0;

    localparam logic [2:0] ACT = 3'd0, RD = 3'd1, WR = 3'd2, PRE = 3'd3,
                           PREA = 3'd4, REF = 3'd5, MRS = 3'd6, RSV = 3'd7;

    ddr2_timing_gate uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_ready(cmd_ready), .cmd_err(cmd_err)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        cmd_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [2:0] op, input logic [2:0] ba, output int t, output int w);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = ba;
        #1;
        w = 0;
        while (!cmd_ready && w < 400) begin
            @(negedge clk); #1; w++;
        end
        t = cyc;
        if (!cmd_ready) check("stuck command", 0, 1);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic try_err(input string tag, input logic [2:0] op, input logic [2:0] ba);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = ba;
        #1;
        check({tag, " err"}, int'(cmd_err), 1);
        check({tag, " ready"}, int'(cmd_ready), 0);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic test_reset();
        int t, w;
        do_reset();
        @(negedge clk); #1;
        check("R1 ready idle", int'(cmd_ready), 0);
        check("R1 err idle", int'(cmd_err), 0);
        send(ACT, 3'd0, t, w);
        check("R1 first act wait", w, 0);
    endtask

    task automatic test_rcd();
        int t0, t1, w;
        do_reset();
        send(ACT, 3'd1, t0, w);
        send(RD, 3'd1, t1, w);
        check("R2 act->rd", t1 - t0, 5);
        do_reset();
        send(ACT, 3'd2, t0, w);
        send(WR, 3'd2, t1, w);
        check("R2 act->wr", t1 - t0, 5);
    endtask

    task automatic test_ras_rp();
        int t0, t1, t2, w;
        do_reset();
        send(ACT, 3'd3, t0, w);
        send(PRE, 3'd3, t1, w);
        check("R3 act->pre", t1 - t0, 18);
        send(ACT, 3'd3, t2, w);
        check("R3 pre->act", t2 - t1, 5);
        check("R3 act->act same bank", t2 - t0, 23);
    endtask

    task automatic test_rrd();
        int t0, t1, w;
        do_reset();
        send(ACT, 3'd0, t0, w);
        send(ACT, 3'd1, t1, w);
        check("R4 act->act other bank", t1 - t0, 3);
    endtask

    task automatic test_faw();
        int t [6];
        int w;
        do_reset();
        for (int i = 0; i < 6; i++) send(ACT, 3'(i), t[i], w);
        check("R5 second act", t[1] - t[0], 3);
        check("R5 fourth act", t[3] - t[0], 9);
        check("R5 fifth act held", t[4] - t[0], 14);
        check("R5 sixth act", t[5] - t[1], 14);
    endtask

    task automatic test_prea();
        int t0, t1, t2, t3, w;
        do_reset();
        send(ACT, 3'd0, t0, w);
        send(PREA, 3'd0, t1, w);
        check("R6 prea waits ras", t1 - t0, 18);
        send(ACT, 3'd0, t2, w);
        check("R6 prea->act", t2 - t1, 6);
        do_reset();
        send(ACT, 3'd0, t0, w);
        send(PREA, 3'd0, t1, w);
        send(MRS, 3'd0, t2, w);
        check("R6 prea->mrs", t2 - t1, 6);
        send(ACT, 3'd1, t3, w);
        check("R8 mrs->act", t3 - t2, 2);
    endtask

    task automatic test_ref();
        int t0, t1, t2, w;
        do_reset();
        send(REF, 3'd0, t0, w);
        send(REF, 3'd0, t1, w);
        check("R7 ref->ref", t1 - t0, 78);
        send(ACT, 3'd4, t2, w);
        check("R7 ref->act", t2 - t1, 78);
    endtask

    task automatic test_mrs();
        int t0, t1, w;
        do_reset();
        send(MRS, 3'd0, t0, w);
        send(MRS, 3'd0, t1, w);
        check("R8 mrs->mrs", t1 - t0, 2);
    endtask

    task automatic test_recovery();
        int t0, t1, t2, w;
        do_reset();
        send(ACT, 3'd0, t0, w);
        idle(20);
        send(WR, 3'd0, t1, w);
        check("R9 late write no wait", w, 0);
        send(PRE, 3'd0, t2, w);
        check("R9 wr->pre", t2 - t1, 12);
        send(ACT, 3'd1, t0, w);
        idle(20);
        send(RD, 3'd1, t1, w);
        send(PRE, 3'd1, t2, w);
        check("R9 rd->pre", t2 - t1, 3);
    endtask

    task automatic test_wtr();
        int t0, t1, w;
        do_reset();
        send(ACT, 3'd0, t0, w);
        send(ACT, 3'd1, t0, w);
        idle(10);
        send(WR, 3'd0, t0, w);
        send(RD, 3'd1, t1, w);
        check("R10 wr->rd other bank", t1 - t0, 9);
    endtask

    task automatic test_err();
        int t0, t1, w;
        do_reset();
        try_err("R11 rd closed", RD, 3'd2);
        send(ACT, 3'd2, t0, w);
        check("R11 act after rejected rd", w, 0);
        try_err("R11 act open", ACT, 3'd2);
        try_err("R11 ref open", REF, 3'd0);
        try_err("R11 mrs open", MRS, 3'd5);
        try_err("R11 code 7", RSV, 3'd1);
        send(RD, 3'd2, t1, w);
        check("R11 rd timing unchanged", t1 - t0, 5);
    endtask

    initial begin
        test_reset();
        test_rcd();
        test_ras_rp();
        test_rrd();
        test_faw();
        test_prea();
        test_ref();
        test_mrs();
        test_recovery();
        test_wtr();
        test_err();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule